// File: doc/BRIEF.md
# Addressable LED Waveform Timing Checker

This block listens to a single-wire serial data line that drives a chain of addressable RGB LEDs and confirms that the waveform on it is correct. It does not drive the line. The checker holds the 24-bit colour word that each LED of the chain should receive, presented as a flat input vector. It measures every high and every low interval in system clock cycles and compares each one with an inclusive window derived from the expected bit.

When a whole frame has been seen correctly, the checker gives a one-cycle pulse and carries on with the next frame. When something is wrong, it records the kind of fault in a sticky flag and bumps a saturating counter. It then drops out of lock until a fresh reset-length low interval shows up on the line.

All nominal times are fixed at elaboration from the clock frequency parameter and a revision parameter. Each time is rounded to the nearest whole cycle, so the block can sit next to a driver in a test chip or in an FPGA bring-up image with no configuration.

Top module: `ledwave_checker`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `in_sync`, `frame_done`, all three error flags and `err_count` are 0. The line passes through two flip-flops before any measurement, so a level change is first acted on in the third clock after it appears at `line_in`.
- R2: Out of lock, the checker enters lock (`in_sync` = 1) only on a rising edge that ends a low interval of at least the reset time. The reset time is 55 µs when `REV_NEW` = 0 and 285 µs when `REV_NEW` = 1. A shorter low followed by a high leaves `in_sync` at 0.
- R3: A high interval passes if its width in cycles lies in [H−T, H+T] inclusive. H is round(0.40 µs) for an expected 0 and round(0.80 µs) for an expected 1. T is round(0.15 µs). Cycles are round(time × CLK_HZ).
- R4: A low interval passes if its width lies in [L−T, L+T] inclusive. L is round(0.85 µs) after a 0 and round(0.45 µs) after a 1. A low outside its window raises `err_width`.
- R5: LED i expects bits `exp_words[24*i+23 : 24*i]`. The most significant bit is checked first, and LEDs are checked in increasing i.
- R6: After the 24th bit of the last LED, the single low that follows must match L plus the reset time, ±T. The rising edge that ends it gives `frame_done` = 1 for exactly one cycle while still in lock, and the next high is checked as bit 23 of LED 0 of a new frame.
- R7: A high whose width falls in the window of the opposite bit raises `err_bit`. Any other failing width raises `err_width`. Either fault clears `in_sync` in the same cycle.
- R8: While in lock, a level that lasts twice the reset time without an edge raises `err_tmo` and clears `in_sync`, once per occurrence.
- R9: Each fault event adds one to `err_count`, which stops at its all-ones value. The three error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Observed LED data line, asynchronous |
| exp_words | input | NUM_LEDS*24 | Expected colour word per LED, LED 0 in the lowest 24 bits |
| in_sync | output | 1 | Checker is locked to a frame |
| frame_done | output | 1 | One-cycle pulse when a full frame has passed |
| err_bit | output | 1 | Sticky: a high had the opposite bit's width |
| err_width | output | 1 | Sticky: a high or low was outside every valid window |
| err_tmo | output | 1 | Sticky: a level lasted twice the reset time while locked |
| err_count | output | CNT_W | Saturating count of fault events |

## Verification
The bench drives every width at the exact edges of the high and low windows, and the closing low of a frame at both ends of its stretched window. A design with an off-by-one bound or a short reset term would flag a good frame or miss a frame pulse. It then presents one cycle beyond a zero-bit window, in the gap between the two high windows, and a low one cycle too long. A design that confuses a bit fault with a width fault, or that skips the low check, would show the wrong flag or the wrong count. A low just short of the reset time must not lock, and a level held past twice the reset time must raise the timeout exactly once. The error counter is pushed past saturation, so a wrapping counter shows up as a drop back to zero.

// File: rtl/ledchk_pkg.sv
// Shared types and timing helpers for the LED waveform checker.
// Assumes nominal times are given in nanoseconds and the clock in hertz.
package ledchk_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } chk_state_e;

    // Nominal times of the line protocol, in nanoseconds.
    localparam int unsigned ZERO_HIGH_NS = 400;
    localparam int unsigned ZERO_LOW_NS  = 850;
    localparam int unsigned ONE_HIGH_NS  = 800;
    localparam int unsigned ONE_LOW_NS   = 450;
    localparam int unsigned TOL_NS       = 150;
    localparam int unsigned LATCH_OLD_NS = 55_000;
    localparam int unsigned LATCH_NEW_NS = 285_000;

    // Number of window comparators: high0, high1, low0, low1, lastlow0, lastlow1.
    localparam int unsigned NUM_WIN = 6;

    // Convert a time in ns to clock cycles, rounded to nearest.
    function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                 input longint unsigned clk_hz);
        longint unsigned prod;
        prod = (ns * clk_hz + 64'd500_000_000) / 64'd1_000_000_000;
        return int'(prod);
    endfunction

endpackage

// File: rtl/ledchk_sync.sv
// Line front end: two-flop synchroniser, edge detector and a saturating
// run-length counter. Assumes line_raw is asynchronous to clk.
// width holds the number of cycles the previous synchronised level lasted
// at the cycle where edge_seen is high; otherwise it holds the current run.
module ledchk_sync #(
    parameter int unsigned CW   = 14,
    parameter int unsigned CMAX = 13750
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_raw,
    output logic          line_lvl,
    output logic          edge_seen,
    output logic [CW-1:0] width
);

    logic [1:0]    meta_q;
    logic          prev_q;
    logic [CW-1:0] run_q;

    // Bring the raw line into the clock domain through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 2'b00;
        end else begin
            meta_q <= {meta_q[0], line_raw};
        end
    end

    // Remember last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= meta_q[1];
        end
    end

    // Count cycles of the current level; restart at an edge, hold at CMAX.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= CW'(1);
        end else if (edge_seen) begin
            run_q <= CW'(1);
        end else if (run_q != CW'(CMAX)) begin
            run_q <= run_q + CW'(1);
        end
    end

    assign line_lvl  = meta_q[1];
    assign edge_seen = meta_q[1] ^ prev_q;
    assign width     = run_q;

endmodule

// File: rtl/ledchk_range.sv
// Inclusive range test of a measured width against [LO, HI].
// Assumes LO <= HI and both fit in CW bits.
module ledchk_range #(
    parameter int unsigned CW = 14,
    parameter int unsigned LO = 0,
    parameter int unsigned HI = 1
) (
    input  logic [CW-1:0] width,
    output logic          hit
);

    // Compare against both bounds at once.
    always_comb begin
        hit = (width >= CW'(LO)) && (width <= CW'(HI));
    end

endmodule

// File: rtl/ledchk_judge.sv
// Window bank: one range comparator per nominal interval and a selector
// that returns the verdict for the expected bit. Assumes TOL is smaller
// than every nominal interval so no window underflows.
module ledchk_judge #(
    parameter int unsigned CW      = 14,
    parameter int unsigned T_H0    = 50,
    parameter int unsigned T_H1    = 100,
    parameter int unsigned T_L0    = 106,
    parameter int unsigned T_L1    = 56,
    parameter int unsigned T_LATCH = 6875,
    parameter int unsigned T_TOL   = 19
) (
    input  logic [CW-1:0] width,
    input  logic          exp_bit,
    input  logic          last_bit,
    output logic          hi_ok,
    output logic          hi_swapped,
    output logic          lo_ok
);

    localparam int unsigned NW = ledchk_pkg::NUM_WIN;
    localparam int unsigned WIN_CTR [NW] = '{
        T_H0, T_H1, T_L0, T_L1, T_L0 + T_LATCH, T_L1 + T_LATCH
    };

    logic [NW-1:0] hit;

    // One comparator per window centre.
    generate
        for (genvar gi = 0; gi < NW; gi++) begin : g_win
            ledchk_range #(
                .CW (CW),
                .LO (WIN_CTR[gi] - T_TOL),
                .HI (WIN_CTR[gi] + T_TOL)
            ) u_range (
                .width (width),
                .hit   (hit[gi])
            );
        end
    endgenerate

    // Pick the windows belonging to the expected bit and position.
    always_comb begin
        hi_ok      = exp_bit ? hit[1] : hit[0];
        hi_swapped = exp_bit ? hit[0] : hit[1];
        if (last_bit) begin
            lo_ok = exp_bit ? hit[5] : hit[4];
        end else begin
            lo_ok = exp_bit ? hit[3] : hit[2];
        end
    end

endmodule

// File: rtl/ledchk_tally.sv
// Fault recorder: three sticky flags and a saturating event counter.
// Assumes at most one fault event per cycle.
module ledchk_tally #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_bit,
    input  logic             ev_width,
    input  logic             ev_tmo,
    output logic             flag_bit,
    output logic             flag_width,
    output logic             flag_tmo,
    output logic [CNT_W-1:0] count
);

    logic any_ev;
    assign any_ev = ev_bit | ev_width | ev_tmo;

    // Latch each fault kind until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_bit   <= 1'b0;
            flag_width <= 1'b0;
            flag_tmo   <= 1'b0;
        end else begin
            if (ev_bit)   flag_bit   <= 1'b1;
            if (ev_width) flag_width <= 1'b1;
            if (ev_tmo)   flag_tmo   <= 1'b1;
        end
    end

    // Count fault events, stopping at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (any_ev && (count != {CNT_W{1'b1}})) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ledwave_checker.sv
// Passive timing checker for a single-wire addressable LED data line.
// Locks on a reset-length low, then walks the expected words MSB first,
// judging every high and low width; a fault drops lock until the next
// reset-length low. Assumes exp_words is stable while frames are checked
// and that CLK_HZ is high enough for the tolerance to be several cycles.
module ledwave_checker #(
    parameter int unsigned CLK_HZ   = 125_000_000,
    parameter int unsigned NUM_LEDS = 4,
    parameter bit          REV_NEW  = 1'b0,
    parameter int unsigned CNT_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_in,
    input  logic [NUM_LEDS*24-1:0] exp_words,
    output logic                   in_sync,
    output logic                   frame_done,
    output logic                   err_bit,
    output logic                   err_width,
    output logic                   err_tmo,
    output logic [CNT_W-1:0]       err_count
);

    import ledchk_pkg::*;

    localparam int unsigned LED_W    = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1;
    localparam int unsigned T_H0     = ns_to_cycles(ZERO_HIGH_NS, CLK_HZ);
    localparam int unsigned T_H1     = ns_to_cycles(ONE_HIGH_NS, CLK_HZ);
    localparam int unsigned T_L0     = ns_to_cycles(ZERO_LOW_NS, CLK_HZ);
    localparam int unsigned T_L1     = ns_to_cycles(ONE_LOW_NS, CLK_HZ);
    localparam int unsigned T_TOL    = ns_to_cycles(TOL_NS, CLK_HZ);
    localparam int unsigned T_LATCH  = ns_to_cycles(REV_NEW ? LATCH_NEW_NS : LATCH_OLD_NS, CLK_HZ);
    localparam int unsigned T_TMO    = 2 * T_LATCH;
    localparam int unsigned CW       = $clog2(T_TMO + 1);
    localparam int unsigned TOP_BIT  = 23;

    logic          line_lvl;
    logic          edge_seen;
    logic [CW-1:0] width;
    logic          rise, fall;

    chk_state_e        state_q, state_d;
    logic [LED_W-1:0]  led_q, led_d;
    logic [4:0]        bit_q, bit_d;
    logic              done_q, done_d;

    logic [23:0] cur_word;
    logic        exp_bit;
    logic        last_bit;
    logic        hi_ok, hi_swapped, lo_ok;
    logic        ev_bit, ev_width, ev_tmo;
    logic        run_expired;

    ledchk_sync #(
        .CW   (CW),
        .CMAX (T_TMO)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_raw  (line_in),
        .line_lvl  (line_lvl),
        .edge_seen (edge_seen),
        .width     (width)
    );

    assign rise        = edge_seen &  line_lvl;
    assign fall        = edge_seen & ~line_lvl;
    assign run_expired = (width == CW'(T_TMO));

    // Select the expected word and bit for the current position.
    always_comb begin
        cur_word = exp_words[led_q*24 +: 24];
        exp_bit  = cur_word[bit_q];
        last_bit = (led_q == LED_W'(NUM_LEDS - 1)) && (bit_q == 5'd0);
    end

    ledchk_judge #(
        .CW      (CW),
        .T_H0    (T_H0),
        .T_H1    (T_H1),
        .T_L0    (T_L0),
        .T_L1    (T_L1),
        .T_LATCH (T_LATCH),
        .T_TOL   (T_TOL)
    ) u_judge (
        .width      (width),
        .exp_bit    (exp_bit),
        .last_bit   (last_bit),
        .hi_ok      (hi_ok),
        .hi_swapped (hi_swapped),
        .lo_ok      (lo_ok)
    );

    // Next-state logic: lock, walk bits, and classify faults.
    always_comb begin
        state_d  = state_q;
        led_d    = led_q;
        bit_d    = bit_q;
        done_d   = 1'b0;
        ev_bit   = 1'b0;
        ev_width = 1'b0;
        ev_tmo   = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (rise && (width >= CW'(T_LATCH))) begin
                    state_d = ST_HIGH;
                    led_d   = '0;
                    bit_d   = 5'(TOP_BIT);
                end
            end
            ST_HIGH: begin
                if (fall) begin
                    if (hi_ok) begin
                        state_d = ST_LOW;
                    end else if (hi_swapped) begin
                        ev_bit  = 1'b1;
                        state_d = ST_HUNT;
                    end else begin
                        ev_width = 1'b1;
                        state_d  = ST_HUNT;
                    end
                end else if (run_expired) begin
                    ev_tmo  = 1'b1;
                    state_d = ST_HUNT;
                end
            end
            ST_LOW: begin
                if (rise) begin
                    if (lo_ok) begin
                        state_d = ST_HIGH;
                        if (last_bit) begin
                            done_d = 1'b1;
                            led_d  = '0;
                            bit_d  = 5'(TOP_BIT);
                        end else if (bit_q == 5'd0) begin
                            led_d = led_q + LED_W'(1);
                            bit_d = 5'(TOP_BIT);
                        end else begin
                            bit_d = bit_q - 5'd1;
                        end
                    end else begin
                        ev_width = 1'b1;
                        state_d  = ST_HUNT;
                    end
                end else if (run_expired) begin
                    ev_tmo  = 1'b1;
                    state_d = ST_HUNT;
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // Register position, state and the frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            led_q   <= '0;
            bit_q   <= 5'(TOP_BIT);
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            led_q   <= led_d;
            bit_q   <= bit_d;
            done_q  <= done_d;
        end
    end

    ledchk_tally #(
        .CNT_W (CNT_W)
    ) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_bit     (ev_bit),
        .ev_width   (ev_width),
        .ev_tmo     (ev_tmo),
        .flag_bit   (err_bit),
        .flag_width (err_width),
        .flag_tmo   (err_tmo),
        .count      (err_count)
    );

    assign in_sync    = (state_q != ST_HUNT);
    assign frame_done = done_q;

endmodule

// File: rtl/ledwave_checker_sva.sv
// Property checker for ledwave_checker, attached by bind below.
// Observes only the top-level ports.
module ledwave_checker_sva #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_sync,
    input logic             frame_done,
    input logic             err_bit,
    input logic             err_width,
    input logic             err_tmo,
    input logic [CNT_W-1:0] err_count
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R6
    AST_DONE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> in_sync); // R6
    AST_BIT_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_bit) |-> !in_sync); // R7
    AST_TMO_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_tmo) |-> !in_sync); // R8
    AST_BIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_bit |=> err_bit); // R9
    AST_WIDTH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_width |=> err_width); // R9
    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_tmo |=> err_tmo); // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (err_count == $past(err_count)) ||
                 (err_count == $past(err_count) + CNT_W'(1))); // R9
    AST_FLAG_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_bit) || $rose(err_width) || $rose(err_tmo)) |-> (err_count != '0)); // R9

endmodule

bind ledwave_checker ledwave_checker_sva #(
    .CNT_W (CNT_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_sync    (in_sync),
    .frame_done (frame_done),
    .err_bit    (err_bit),
    .err_width  (err_width),
    .err_tmo    (err_tmo),
    .err_count  (err_count)
);

// File: tb/ledwave_checker_bench.sv
// Bench: drives waveforms onto the line and compares every output on every
// clock against a behavioural model, plus directed checks per scenario.
module ledwave_checker_bench;

    localparam int N      = 2;
    localparam int CNT_W  = 2;
    localparam int T_H0   = (400 * 125 + 500) / 1000;
    localparam int T_H1   = (800 * 125 + 500) / 1000;
    localparam int T_L0   = (850 * 125 + 500) / 1000;
    localparam int T_L1   = (450 * 125 + 500) / 1000;
    localparam int TOL    = (150 * 125 + 500) / 1000;
    localparam int RST    = (55000 * 125 + 500) / 1000;
    localparam int TMO    = 2 * RST;
    localparam logic [23:0] W0 = 24'hA53C0F;
    localparam logic [23:0] W1 = 24'h5AC3F0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b0;
    logic [N*24-1:0] exp_vec;
    logic in_sync, frame_done, err_bit, err_width, err_tmo;
    logic [CNT_W-1:0] err_count;
    logic [23:0] words [N];

    int total = 0;
    int bad = 0;
    int frames_seen = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign exp_vec = {W1, W0};
    initial begin
        words[0] = W0;
        words[1] = W1;
    end

    ledwave_checker #(
        .CLK_HZ   (125_000_000),
        .NUM_LEDS (N),
        .REV_NEW  (1'b0),
        .CNT_W    (CNT_W)
    ) u_ledwave_checker (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line),
        .exp_words  (exp_vec),
        .in_sync    (in_sync),
        .frame_done (frame_done),
        .err_bit    (err_bit),
        .err_width  (err_width),
        .err_tmo    (err_tmo),
        .err_count  (err_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int s1, s2, s3, mcnt, mst, mled, mbit, mcount, ev;
    bit mdone, mfb, mfw, mft;

    function automatic bit in_win(input int w, input int ctr);
        return (w >= ctr - TOL) && (w <= ctr + TOL);
    endfunction

    always @(posedge clk) begin
        bit e, r, f, eb, lb;
        int w;
        if (!rst_n) begin
            s1 = 0; s2 = 0; s3 = 0; mcnt = 1; mst = 0; mled = 0; mbit = 23;
            mdone = 0; mfb = 0; mfw = 0; mft = 0; mcount = 0;
        end else begin
            e  = (s2 != s3);
            r  = e && (s2 == 1);
            f  = e && (s2 == 0);
            w  = mcnt;
            eb = words[mled][mbit];
            lb = (mled == N - 1) && (mbit == 0);
            mdone = 0;
            ev = 0;
            if (mst == 0) begin
                if (r && w >= RST) begin mst = 1; mled = 0; mbit = 23; end
            end else if (mst == 1) begin
                if (f) begin
                    if (in_win(w, eb ? T_H1 : T_H0)) mst = 2;
                    else if (in_win(w, eb ? T_H0 : T_H1)) begin ev = 1; mst = 0; end
                    else begin ev = 2; mst = 0; end
                end else if (w == TMO) begin ev = 3; mst = 0; end
            end else begin
                if (r) begin
                    if (in_win(w, (eb ? T_L1 : T_L0) + (lb ? RST : 0))) begin
                        mst = 1;
                        if (lb) begin mdone = 1; mled = 0; mbit = 23; end
                        else if (mbit == 0) begin mled++; mbit = 23; end
                        else mbit--;
                    end else begin ev = 2; mst = 0; end
                end else if (w == TMO) begin ev = 3; mst = 0; end
            end
            if (ev == 1) mfb = 1;
            if (ev == 2) mfw = 1;
            if (ev == 3) mft = 1;
            if (ev != 0 && mcount < 3) mcount++;
            if (e) mcnt = 1; else if (mcnt < TMO) mcnt++;
            s3 = s2; s2 = s1; s1 = int'(line);
        end
        cmp_on = 1'b1;
    end

    // Compare every output against the model away from the clock edge.
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk("R2 in_sync vs model",     int'(in_sync),    int'(mst != 0));
            chk("R6 frame_done vs model",  int'(frame_done), int'(mdone));
            chk("R7 err_bit vs model",     int'(err_bit),    int'(mfb));
            chk("R3/R4 err_width vs model", int'(err_width), int'(mfw));
            chk("R8 err_tmo vs model",     int'(err_tmo),    int'(mft));
            chk("R9 err_count vs model",   int'(err_count),  mcount);
            if (frame_done) frames_seen++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic hold(input logic v, input int n);
        line = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input int mode);
        for (int l = 0; l < N; l++) begin
            for (int b = 23; b >= 0; b--) begin
                bit v;
                int hi, lo;
                v = words[l][b];
                if (mode == 1) begin hi = v ? 81 : 31;  lo = v ? 37 : 87;  end
                else if (mode == 2) begin hi = v ? 119 : 69; lo = v ? 75 : 125; end
                else begin hi = v ? 100 : 50; lo = v ? 56 : 106; end
                if (l == N - 1 && b == 0) lo += RST;
                hold(1'b1, hi);
                hold(1'b0, lo);
            end
        end
    endtask

    initial begin
        @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R1 reset in_sync", int'(in_sync), 0);
        chk("R1 reset err_count", int'(err_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first cycle flags", int'({err_bit, err_width, err_tmo, frame_done}), 0);

        // Low shorter than the reset time must not lock.
        hold(1'b0, 6000);
        hold(1'b1, 50);
        hold(1'b0, 100);
        chk("R2 short low no lock", int'(in_sync), 0);
        hold(1'b0, 6900);

        // Good frames: nominal, nominal, minimum widths, maximum widths.
        send_frame(0);
        chk("R2 locked after reset low", int'(in_sync), 1);
        send_frame(0);
        chk("R5 R6 one frame passed", frames_seen, 1);
        send_frame(1);
        send_frame(2);
        chk("R3 R4 window edges pass", frames_seen, 3);
        chk("R3 R4 no errors on edges", int'(err_count), 0);

        // Opposite-bit high: expected 1 at LED0 bit 23, send zero shape.
        hold(1'b1, T_H0);
        hold(1'b0, 20);
        chk("R6 frame after max frame", frames_seen, 4);
        chk("R7 bit error flagged", int'(err_bit), 1);
        chk("R7 bit error drops lock", int'(in_sync), 0);
        chk("R9 count after bit error", int'(err_count), 1);

        // High one cycle past the zero window (bit 22 of LED0 is 0).
        hold(1'b0, RST + 10);
        hold(1'b1, T_H1);
        hold(1'b0, T_L1);
        hold(1'b1, T_H0 + TOL + 1);
        hold(1'b0, 20);
        chk("R3 high out of window", int'(err_width), 1);
        chk("R7 width error not bit", int'(err_count), 2);

        // Low one cycle past the one-bit low window.
        hold(1'b0, RST + 10);
        hold(1'b1, T_H1);
        hold(1'b0, T_L1 + TOL + 1);
        hold(1'b1, T_H0);
        hold(1'b0, 20);
        chk("R4 long low flagged", int'(err_count), 3);

        // Timeout while locked: counter already saturated.
        hold(1'b0, RST + 10);
        hold(1'b1, TMO + 250);
        chk("R8 timeout flagged", int'(err_tmo), 1);
        chk("R8 timeout drops lock", int'(in_sync), 0);
        hold(1'b0, 30);
        chk("R9 count saturates", int'(err_count), 3);
        chk("R9 flags sticky", int'({err_bit, err_width}), 3);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190_000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule